// File: doc/BRIEF.md
# ATA Device Ready Poller

This block is a host-side sequencer that waits for an ATA device to become ready before a command or data phase goes ahead. After a start strobe it reads the alternate status register over a byte-wide request/acknowledge register bus. The first phase waits for the busy flag to drop. If the caller supplied a nonzero mask, a second phase then waits until every bit of that mask reads as set. The block ends with a one-cycle done pulse, a small signed result code and the last status byte it read.

All delays are counted in microsecond ticks that come from outside the block. The busy phase has a fixed total budget. Polls inside that budget are spaced closely at first and widely later. A status byte of all ones means nothing is driving the bus. In that case the block rewrites the device-select register and charges a penalty against the busy budget, so a missing device still ends in a timeout.

Top module: `ata_ready_poller`

## Requirements
- R1: Out of reset, `done`, `bus_req`, `result` and `last_status` are all zero.
- R2: The busy phase reads bus address 7 (alternate status) repeatedly until a byte arrives whose bit 7 (busy) is 0 and which is not 0xFF. `last_status` always holds the byte from the most recent read.
- R3: When a status read returns 0xFF, the block writes {3'b101, unit, 4'b0000} (0xA0 or 0xB0) to bus address 6 (device select). It adds FLOAT_STEP_US to the elapsed budget and waits that long before the next read.
- R4: Each busy read adds FAST_STEP_US to the elapsed budget and waits that long while the elapsed budget is at most FAST_LIMIT_US. Once the elapsed budget is above FAST_LIMIT_US, each busy read adds and waits SLOW_STEP_US instead.
- R5: Before every busy-phase read the elapsed budget is compared with BUSY_BUDGET_US. If it has reached the budget, the block finishes with result 3'b110 (-2).
- R6: With a zero mask, the block finishes right after the busy phase. The result is 3'b001 if bit 0 (error) of the final status is set and 3'b000 otherwise.
- R7: With a nonzero mask, the block reads status up to MASK_POLLS times, MASK_STEP_US apart. On the first read where (status & mask) == mask it finishes with the error-bit result of R6. If no read matches, it waits one more step and finishes with 3'b101 (-3).
- R8: A settling wait of SETTLE_US ticks comes before the first read of each phase.
- R9: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` stable until `bus_ack`. Only one access is outstanding at a time, and only the device-select register is ever written.
- R10: `done` is a single-cycle pulse. `result` and `last_status` hold their values until the next completion.
- R11: A `start` pulse that arrives while a wait is running is ignored, including its mask and unit. A `start` in the same cycle as `done` begins a new wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a wait (ignored while busy) |
| wait_mask | input | 8 | Status bits required in phase two; zero skips phase two |
| unit_sel | input | 1 | Device unit placed in the select byte |
| done | output | 1 | Completion pulse |
| result | output | 3 | 0 ok, 1 error bit, 3'b110 busy timeout, 3'b101 mask timeout |
| last_status | output | 8 | Most recent status byte read |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 3 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
Two functions can land on the same decision. A floating-bus read can be the one whose penalty pushes the elapsed budget past its limit, and a new start can arrive in the very cycle that the previous completion is pulsed. The first case is provoked by a device that answers 0xFF forever. It is judged by counting both the reselect writes and the reads, and by checking that the final result is still the busy timeout. The second case raises start while done is high. The bench then expects the second wait to run to its own scored result, with the read and write counts of each wait kept apart.

// File: rtl/ata_poll_pkg.sv
package ata_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE_A, ST_READ_A, ST_RESEL, ST_WAIT_A,
    ST_SETTLE_B, ST_READ_B, ST_WAIT_B
  } poll_state_t;

  localparam logic [2:0] RC_OK      = 3'b000;
  localparam logic [2:0] RC_ERR     = 3'b001;
  localparam logic [2:0] RC_BUSY_TO = 3'b110;
  localparam logic [2:0] RC_MASK_TO = 3'b101;

  localparam logic [2:0] ADDR_DEVSEL  = 3'd6;
  localparam logic [2:0] ADDR_ALTSTAT = 3'd7;

  localparam int STAT_BUSY_BIT = 7;
  localparam int STAT_ERR_BIT  = 0;
  localparam logic [7:0] STAT_FLOAT = 8'hFF;
endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/reg_bus_port.sv
module reg_bus_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic       issue_we,
  input  logic [2:0] issue_addr,
  input  logic [7:0] issue_wdata,
  output logic       bus_req,
  output logic       bus_we,
  output logic [2:0] bus_addr,
  output logic [7:0] bus_wdata,
  input  logic       bus_ack,
  output logic       xfer_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (issue) begin
      bus_req   <= 1'b1;
      bus_we    <= issue_we;
      bus_addr  <= issue_addr;
      bus_wdata <= issue_wdata;
    end else if (bus_req && bus_ack) begin
      bus_req <= 1'b0;
    end
  end

  assign xfer_done = bus_req && bus_ack;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  // R9
  single_access_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> !bus_req);
endmodule

// File: rtl/ata_ready_poller.sv
module ata_ready_poller
  import ata_poll_pkg::*;
#(
  parameter int BUSY_BUDGET_US = 1000000,
  parameter int FAST_LIMIT_US  = 1000,
  parameter int FAST_STEP_US   = 10,
  parameter int SLOW_STEP_US   = 1000,
  parameter int FLOAT_STEP_US  = 1000,
  parameter int MASK_POLLS     = 5000,
  parameter int MASK_STEP_US   = 10,
  parameter int SETTLE_US      = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_us,
  input  logic       start,
  input  logic [7:0] wait_mask,
  input  logic       unit_sel,
  output logic       done,
  output logic [2:0] result,
  output logic [7:0] last_status,
  output logic       bus_req,
  output logic       bus_we,
  output logic [2:0] bus_addr,
  output logic [7:0] bus_wdata,
  input  logic [7:0] bus_rdata,
  input  logic       bus_ack
);
  localparam int ELAPSED_W = $clog2(BUSY_BUDGET_US + SLOW_STEP_US + FLOAT_STEP_US + FAST_STEP_US + 1);
  localparam int TMR_W     = $clog2(FAST_STEP_US + SLOW_STEP_US + FLOAT_STEP_US + MASK_STEP_US + SETTLE_US + 1);
  localparam int POLL_W    = $clog2(MASK_POLLS + 1);

  localparam logic [ELAPSED_W-1:0] BUDGET_E = ELAPSED_W'(BUSY_BUDGET_US);
  localparam logic [ELAPSED_W-1:0] LIMIT_E  = ELAPSED_W'(FAST_LIMIT_US);
  localparam logic [ELAPSED_W-1:0] FAST_E   = ELAPSED_W'(FAST_STEP_US);
  localparam logic [ELAPSED_W-1:0] SLOW_E   = ELAPSED_W'(SLOW_STEP_US);
  localparam logic [ELAPSED_W-1:0] FLOAT_E  = ELAPSED_W'(FLOAT_STEP_US);

  poll_state_t          state;
  logic [7:0]           mask_q;
  logic                 unit_q;
  logic [ELAPSED_W-1:0] elapsed;
  logic [POLL_W-1:0]    polls;

  logic             issue_q, issue_we_q;
  logic [2:0]       issue_addr_q;
  logic             tmr_load_q;
  logic [TMR_W-1:0] tmr_val_q;
  logic             tmr_expired, tmr_ready, xfer_done;
  logic [7:0]       sel_byte;

  assign sel_byte  = {3'b101, unit_q, 4'b0000};
  assign tmr_ready = tmr_expired && !tmr_load_q;

  poll_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load_q), .load_val(tmr_val_q),
    .tick(tick_us), .expired(tmr_expired)
  );

  reg_bus_port u_bus (
    .clk(clk), .rst(rst), .issue(issue_q), .issue_we(issue_we_q),
    .issue_addr(issue_addr_q), .issue_wdata(sel_byte),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .xfer_done(xfer_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mask_q       <= '0;
      unit_q       <= 1'b0;
      elapsed      <= '0;
      polls        <= '0;
      issue_q      <= 1'b0;
      issue_we_q   <= 1'b0;
      issue_addr_q <= ADDR_ALTSTAT;
      tmr_load_q   <= 1'b0;
      tmr_val_q    <= '0;
      done         <= 1'b0;
      result       <= RC_OK;
      last_status  <= '0;
    end else begin
      done       <= 1'b0;
      issue_q    <= 1'b0;
      tmr_load_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          mask_q     <= wait_mask;
          unit_q     <= unit_sel;
          elapsed    <= '0;
          tmr_val_q  <= TMR_W'(SETTLE_US);
          tmr_load_q <= 1'b1;
          state      <= ST_SETTLE_A;
        end
        ST_SETTLE_A: if (tmr_ready) begin
          issue_q      <= 1'b1;
          issue_we_q   <= 1'b0;
          issue_addr_q <= ADDR_ALTSTAT;
          state        <= ST_READ_A;
        end
        ST_READ_A: if (xfer_done) begin
          last_status <= bus_rdata;
          if (bus_rdata == STAT_FLOAT) begin
            elapsed      <= elapsed + FLOAT_E;
            issue_q      <= 1'b1;
            issue_we_q   <= 1'b1;
            issue_addr_q <= ADDR_DEVSEL;
            state        <= ST_RESEL;
          end else if (!bus_rdata[STAT_BUSY_BIT]) begin
            if (mask_q == '0) begin
              done   <= 1'b1;
              result <= bus_rdata[STAT_ERR_BIT] ? RC_ERR : RC_OK;
              state  <= ST_IDLE;
            end else begin
              tmr_val_q  <= TMR_W'(SETTLE_US);
              tmr_load_q <= 1'b1;
              state      <= ST_SETTLE_B;
            end
          end else begin
            tmr_load_q <= 1'b1;
            if (elapsed > LIMIT_E) begin
              elapsed   <= elapsed + SLOW_E;
              tmr_val_q <= TMR_W'(SLOW_STEP_US);
            end else begin
              elapsed   <= elapsed + FAST_E;
              tmr_val_q <= TMR_W'(FAST_STEP_US);
            end
            state <= ST_WAIT_A;
          end
        end
        ST_RESEL: if (xfer_done) begin
          tmr_val_q  <= TMR_W'(FLOAT_STEP_US);
          tmr_load_q <= 1'b1;
          state      <= ST_WAIT_A;
        end
        ST_WAIT_A: if (tmr_ready) begin
          if (elapsed < BUDGET_E) begin
            issue_q      <= 1'b1;
            issue_we_q   <= 1'b0;
            issue_addr_q <= ADDR_ALTSTAT;
            state        <= ST_READ_A;
          end else begin
            done   <= 1'b1;
            result <= RC_BUSY_TO;
            state  <= ST_IDLE;
          end
        end
        ST_SETTLE_B: if (tmr_ready) begin
          polls        <= '0;
          issue_q      <= 1'b1;
          issue_we_q   <= 1'b0;
          issue_addr_q <= ADDR_ALTSTAT;
          state        <= ST_READ_B;
        end
        ST_READ_B: if (xfer_done) begin
          last_status <= bus_rdata;
          if ((bus_rdata & mask_q) == mask_q) begin
            done   <= 1'b1;
            result <= bus_rdata[STAT_ERR_BIT] ? RC_ERR : RC_OK;
            state  <= ST_IDLE;
          end else begin
            polls      <= polls + 1'b1;
            tmr_val_q  <= TMR_W'(MASK_STEP_US);
            tmr_load_q <= 1'b1;
            state      <= ST_WAIT_B;
          end
        end
        ST_WAIT_B: if (tmr_ready) begin
          if (polls == POLL_W'(MASK_POLLS)) begin
            done   <= 1'b1;
            result <= RC_MASK_TO;
            state  <= ST_IDLE;
          end else begin
            issue_q      <= 1'b1;
            issue_we_q   <= 1'b0;
            issue_addr_q <= ADDR_ALTSTAT;
            state        <= ST_READ_B;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  budget_spent_chk: assert property (@(posedge clk) disable iff (rst)
    (done && result == RC_BUSY_TO) |-> (elapsed >= BUDGET_E));
  // R3
  resel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> (bus_addr == ADDR_DEVSEL && bus_wdata == {3'b101, unit_q, 4'b0000}));
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> ($stable(mask_q) && $stable(unit_q)));
  // R7
  mask_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    (done && result == RC_MASK_TO) |-> (mask_q != '0));
endmodule

// File: tb/ata_ready_poller_test.sv
module ata_ready_poller_test;
  localparam int BUDGET = 200, FLIM = 40, FSTEP = 4, SSTEP = 20, FLSTEP = 20;
  localparam int MPOLLS = 6, MSTEP = 4, SETTLE = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, start = 1'b0, unit_sel = 1'b0;
  logic [7:0] wait_mask = '0, bus_rdata = '0;
  logic bus_ack = 1'b0;
  logic done, bus_req, bus_we;
  logic [2:0] result, bus_addr;
  logic [7:0] last_status, bus_wdata;

  always #5 clk = ~clk;

  ata_ready_poller #(
    .BUSY_BUDGET_US(BUDGET), .FAST_LIMIT_US(FLIM), .FAST_STEP_US(FSTEP),
    .SLOW_STEP_US(SSTEP), .FLOAT_STEP_US(FLSTEP), .MASK_POLLS(MPOLLS),
    .MASK_STEP_US(MSTEP), .SETTLE_US(SETTLE)
  ) uut (
    .clk(clk), .rst(rst), .tick_us(tick), .start(start), .wait_mask(wait_mask),
    .unit_sel(unit_sel), .done(done), .result(result), .last_status(last_status),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  typedef struct { logic [2:0] res; logic [7:0] st; int reads; int sels; } exp_t;
  exp_t sb[$];
  logic [7:0] script [64];
  int sidx = 0, reads_total = 0, sels_total = 0, reads_base = 0, sels_base = 0;
  int checks = 0, fails = 0;
  logic exp_unit = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) tick <= rst ? 1'b0 : ~tick;

  // bus slave model: acknowledges one cycle after a request
  always @(negedge clk) begin
    if (rst) bus_ack = 1'b0;
    else if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      bus_ack = 1'b1;
      if (bus_we) begin
        sels_total++;
        check(bus_addr == 3'd6 && bus_wdata == {3'b101, exp_unit, 4'b0000}, "R3", "reselect write",
              {bus_addr, bus_wdata}, {3'd6, 3'b101, exp_unit, 4'b0000});
      end else begin
        reads_total++;
        check(bus_addr == 3'd7, "R2", "status read address", bus_addr, 7);
        bus_rdata = script[sidx];
        if (sidx < 63) sidx++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) check(1'b0, "R11", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res, "R5/R6/R7", "result", result, e.res);
        check(last_status == e.st, "R2", "last_status", last_status, e.st);
        check(reads_total - reads_base == e.reads, "R4", "read count", reads_total - reads_base, e.reads);
        check(sels_total - sels_base == e.sels, "R3", "reselect count", sels_total - sels_base, e.sels);
      end
      reads_base = reads_total;
      sels_base  = sels_total;
    end
  end

  function automatic exp_t predict(input logic [7:0] mask);
    exp_t e;
    int el = 0, i = 0;
    logic [7:0] s = '0;
    e.reads = 0; e.sels = 0; e.st = '0; e.res = 3'b000;
    while (1) begin
      if (el >= BUDGET) begin e.res = 3'b110; return e; end
      s = script[i]; if (i < 63) i++;
      e.reads++; e.st = s;
      if (s == 8'hFF) begin e.sels++; el += FLSTEP; continue; end
      if (!s[7]) break;
      el += (el > FLIM) ? SSTEP : FSTEP;
    end
    if (mask == 8'h00) begin e.res = {2'b00, s[0]}; return e; end
    for (int p = 0; p < MPOLLS; p++) begin
      s = script[i]; if (i < 63) i++;
      e.reads++; e.st = s;
      if ((s & mask) == mask) begin e.res = {2'b00, s[0]}; return e; end
    end
    e.res = 3'b101;
    return e;
  endfunction

  task automatic fill(input logic [7:0] v);
    for (int k = 0; k < 64; k++) script[k] = v;
    sidx = 0;
  endtask

  task automatic launch(input logic [7:0] mask, input logic unit);
    sb.push_back(predict(mask));
    wait_mask = mask; unit_sel = unit; exp_unit = unit;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) check(1'b0, "R10", "done timeout", 0, 1);
  endtask

  task automatic run(input logic [7:0] mask, input logic unit);
    launch(mask, unit);
    wait_done();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    fill(8'h50);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!done && !bus_req && result == 3'b000 && last_status == 8'h00, "R1", "reset outputs",
          {done, bus_req, result, last_status}, 0);

    // R8 settle before first read; R6 ready at once, no error
    begin
      int ticks = 0;
      launch(8'h00, 1'b0);
      while (!bus_req) begin
        if (tick) ticks++;
        @(negedge clk);
      end
      check(ticks >= SETTLE, "R8", "ticks before first read", ticks, SETTLE);
      wait_done();
      repeat (4) @(negedge clk);
    end

    // R6 busy then ready with error bit
    fill(8'h51); script[0] = 8'h80; script[1] = 8'h80; script[2] = 8'h80;
    run(8'h00, 1'b0);

    // R4 R5 never ready: fast then slow spacing, busy timeout
    fill(8'h80);
    run(8'h00, 1'b0);

    // R4 long busy into slow region then ready
    fill(8'h50); for (int k = 0; k < 15; k++) script[k] = 8'hD0;
    run(8'h00, 1'b1);

    // R3 floating bus twice then phase two success
    fill(8'h48); script[0] = 8'hFF; script[1] = 8'hFF; script[2] = 8'h40;
    run(8'h40, 1'b1);

    // R7 mask never satisfied; R11 start mid-run ignored
    fill(8'h40);
    launch(8'h08, 1'b0);
    repeat (10) @(negedge clk);
    wait_mask = 8'h00; unit_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (200) @(negedge clk);
    check(sb.size() == 0, "R11", "pending items after ignored start", sb.size(), 0);

    // R7 mask met after several polls, error set
    fill(8'h40); script[0] = 8'h80; script[4] = 8'h49;
    run(8'h48, 1'b0);

    // R3 R5 floating forever: penalty crosses budget, then back-to-back start (R11)
    fill(8'hFF);
    launch(8'h00, 1'b1);
    wait_done();
    fill(8'h50);
    launch(8'h00, 1'b0);
    wait_done();
    repeat (200) @(negedge clk);
    check(sb.size() == 0, "R11", "back-to-back start served", sb.size(), 0);
    // R10 outputs held after completion
    check(result == 3'b000 && last_status == 8'h50 && !done, "R10", "held outputs",
          {done, result, last_status}, 8'h50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule